// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block takes received Ethernet frames one at a time from a byte stream with a last flag and places each one in host memory using a ring of receive descriptors. At the start of a frame it checks the receive-enable input. If receive is enabled, it holds the stream while it reads the current 32-byte descriptor through a single request/acknowledge memory port. It then streams the frame bytes into the descriptor's first buffer, packed little-endian into 32-bit words. At the end of the frame it writes a completion word back over the descriptor's control word, and it moves the ring pointer forward or back to the ring base.

Each outcome signals its own one-cycle status pulses. The block also keeps running counts of frames, bytes (including the four CRC bytes that are never stored), broadcast frames and multicast frames. Software sets the ring base with a one-cycle load strobe, and this also resets the current descriptor pointer to the base.

Top module: `rxwb_engine`

## Requirements
- R1: A frame whose first byte arrives while `rx_en_i` is low is consumed up to and including its last byte. It issues no memory access, raises no pulse and changes no counter or pointer.
- R2: With receive enabled, no frame byte is accepted until the three descriptor words at pointer+0, pointer+4 and pointer+8 have been read.
- R3: Frame bytes are written from the address held in the word at pointer+8. Byte n goes to lane n mod 4 of word n/4. A final partial word enables only its filled lanes, so the bytes after the frame keep their old contents.
- R4: After a stored frame, the word at the pointer is overwritten with ((length + 4) << 16) | 0x300. This clears bit 31, the ownership bit.
- R5: After writeback, the pointer reloads from the base if bit 15 of the word at pointer+4 is set, and otherwise advances by 32. A base load sets both the base and the pointer.
- R6: A frame shorter than 12 bytes raises `irq_rx_o` and `irq_norm_o` for one cycle. It gets no writeback, no pointer move and no counter change. This outcome takes priority over a missing ownership bit.
- R7: A frame of 12 or more bytes whose descriptor word 0 has bit 31 clear is discarded. No buffer bytes are written, `irq_nobuf_o` and `irq_abn_o` pulse for one cycle, and the pointer and counters are unchanged.
- R8: A frame whose first six bytes are all 0xFF counts as broadcast. A frame with bit 0 of its first byte set that is not broadcast counts as multicast.
- R9: A stored frame raises `irq_rx_o` and `irq_norm_o` for one cycle. In that same cycle the frame counter rises by one, the byte counter by length + 4, and the matching class counter by one. Counters change in no other cycle.
- R10: A memory request stays asserted with a stable address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable, sampled at frame start |
| base_we_i | input | 1 | Load strobe for ring base and pointer |
| base_i | input | AW | Ring base byte address |
| s_data_i | input | 8 | Frame byte |
| s_valid_i | input | 1 | Byte valid |
| s_last_i | input | 1 | Byte is the last of the frame |
| s_ready_o | output | 1 | Byte accepted when high with valid |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_be_o | output | 4 | Write byte enables |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| cur_desc_o | output | AW | Current descriptor pointer |
| irq_rx_o | output | 1 | Receive-done pulse |
| irq_norm_o | output | 1 | Normal summary pulse |
| irq_nobuf_o | output | 1 | No-buffer pulse |
| irq_abn_o | output | 1 | Abnormal summary pulse |
| cnt_bytes_o | output | CW | Byte count including CRC |
| cnt_frames_o | output | CW | Stored frame count |
| cnt_bcast_o | output | CW | Broadcast frame count |
| cnt_mcast_o | output | CW | Multicast frame count |

## Verification
The embedded assertions check four rules on every cycle: memory requests are held until acknowledged, counters move only together with a receive-done pulse, the pointer moves only on a base load or a completed frame, and the no-buffer and receive-done pulses never coincide. The bench scenarios alone can show the rest. That covers byte packing and preservation of the lanes after the frame, the exact completion word, the choice between wrap and advance, the priority of short frames over missing ownership, frame classification, and a disabled frame consumed without side effects.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DATA, ST_END, ST_WB, ST_SKIP
  } rx_state_e;

  localparam int OWN_POS    = 31;
  localparam int RING_POS   = 15;
  localparam int DESC_BYTES = 32;
  localparam int CRC_BYTES  = 4;
  localparam int MIN_LEN    = 12;
  localparam int DA_BYTES   = 6;
endpackage

// File: rtl/rxwb_classify.sv
module rxwb_classify #(
  parameter int LW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          fire_i,
  input  logic [7:0]    byte_i,
  output logic [LW-1:0] len_o,
  output logic          bcast_o,
  output logic          mcast_o
);
  import rxwb_pkg::*;

  logic [LW-1:0] len_q;
  logic          all_ff_q;
  logic          grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q    <= '0;
      all_ff_q <= 1'b1;
      grp_q    <= 1'b0;
    end else if (clr_i) begin
      len_q    <= '0;
      all_ff_q <= 1'b1;
      grp_q    <= 1'b0;
    end else if (fire_i) begin
      len_q <= len_q + LW'(1);
      if (len_q < LW'(DA_BYTES) && byte_i != 8'hFF) all_ff_q <= 1'b0;
      if (len_q == '0) grp_q <= byte_i[0];
    end
  end

  assign len_o   = len_q;
  assign bcast_o = all_ff_q && (len_q >= LW'(DA_BYTES));
  assign mcast_o = grp_q && !bcast_o;
endmodule

// File: rtl/rxwb_pack.sv
module rxwb_pack #(
  parameter int IW = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          fire_i,
  input  logic [7:0]    byte_i,
  input  logic          last_i,
  input  logic          keep_i,
  input  logic          done_i,
  output logic          pend_o,
  output logic [31:0]   word_o,
  output logic [3:0]    be_o,
  output logic [IW-1:0] widx_o
);
  logic [1:0]    lane_q;
  logic [3:0]    be_q;
  logic          pend_q;
  logic [IW-1:0] widx_q;
  logic [3:0]    lane_bit;

  assign lane_bit = 4'b0001 << lane_q;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] lane_byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lane_byte_q <= '0;
      else if (fire_i && lane_q == 2'(g)) lane_byte_q <= byte_i;
    end
    assign word_o[8*g +: 8] = lane_byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q <= '0;
      be_q   <= '0;
      pend_q <= 1'b0;
      widx_q <= '0;
    end else if (clr_i) begin
      lane_q <= '0;
      be_q   <= '0;
      pend_q <= 1'b0;
      widx_q <= '0;
    end else begin
      if (done_i) begin
        pend_q <= 1'b0;
        be_q   <= '0;
        widx_q <= widx_q + IW'(1);
      end
      if (fire_i) begin
        if (lane_q == 2'd3 || last_i) begin
          lane_q <= '0;
          if (keep_i) begin
            pend_q <= 1'b1;
            be_q   <= be_q | lane_bit;
          end else begin
            be_q <= '0;
          end
        end else begin
          lane_q <= lane_q + 2'd1;
          be_q   <= be_q | lane_bit;
        end
      end
    end
  end

  assign pend_o = pend_q;
  assign be_o   = be_q;
  assign widx_o = widx_q;

  a_r3_no_fill_while_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !fire_i);
endmodule

// File: rtl/rxwb_stats.sv
module rxwb_stats #(
  parameter int LW = 14,
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic [LW:0]   add_i,
  input  logic          bcast_i,
  input  logic          mcast_i,
  output logic [CW-1:0] bytes_o,
  output logic [CW-1:0] frames_o,
  output logic [CW-1:0] bcast_o,
  output logic [CW-1:0] mcast_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bytes_o  <= '0;
      frames_o <= '0;
      bcast_o  <= '0;
      mcast_o  <= '0;
    end else if (commit_i) begin
      bytes_o  <= bytes_o + CW'(add_i);
      frames_o <= frames_o + CW'(1);
      if (bcast_i) bcast_o <= bcast_o + CW'(1);
      if (mcast_i) mcast_o <= mcast_o + CW'(1);
    end
  end

  a_r8_class_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> !(bcast_i && mcast_i));
endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine #(
  parameter int AW = 32,
  parameter int LW = 14,
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_en_i,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  input  logic [7:0]    s_data_i,
  input  logic          s_valid_i,
  input  logic          s_last_i,
  output logic          s_ready_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic [3:0]    mem_be_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic [AW-1:0] cur_desc_o,
  output logic          irq_rx_o,
  output logic          irq_norm_o,
  output logic          irq_nobuf_o,
  output logic          irq_abn_o,
  output logic [CW-1:0] cnt_bytes_o,
  output logic [CW-1:0] cnt_frames_o,
  output logic [CW-1:0] cnt_bcast_o,
  output logic [CW-1:0] cnt_mcast_o
);
  import rxwb_pkg::*;

  localparam int IW = AW - 2;

  rx_state_e     state_q;
  logic [1:0]    fidx_q;
  logic          own_q, ring_q, last_seen_q;
  logic [AW-1:0] buf_q, ptr_q, base_q;

  logic          frame_start, fire_data, pk_done, pend;
  logic [31:0]   pk_word;
  logic [3:0]    pk_be;
  logic [IW-1:0] widx;
  logic [LW-1:0] len;
  logic          is_bcast, is_mcast;
  logic [LW:0]   wb_len;
  logic [31:0]   ctl_word;
  logic          short_ev, nobuf_ev, commit;

  assign frame_start = (state_q == ST_IDLE) && s_valid_i && rx_en_i;
  assign s_ready_o   = ((state_q == ST_DATA) && !pend && !last_seen_q) ||
                       (state_q == ST_SKIP);
  assign fire_data   = (state_q == ST_DATA) && s_valid_i && s_ready_o;
  assign pk_done     = (state_q == ST_DATA) && pend && mem_ack_i;
  assign wb_len      = {1'b0, len} + (LW+1)'(CRC_BYTES);
  assign ctl_word    = {16'(wb_len), 16'h0300};
  assign short_ev    = (state_q == ST_END) && (len < LW'(MIN_LEN));
  assign nobuf_ev    = (state_q == ST_END) && !short_ev && !own_q;
  assign commit      = (state_q == ST_WB) && mem_ack_i;

  rxwb_classify #(.LW(LW)) u_class (
    .clk_i, .rst_ni,
    .clr_i   (frame_start),
    .fire_i  (fire_data),
    .byte_i  (s_data_i),
    .len_o   (len),
    .bcast_o (is_bcast),
    .mcast_o (is_mcast)
  );

  rxwb_pack #(.IW(IW)) u_pack (
    .clk_i, .rst_ni,
    .clr_i  (frame_start),
    .fire_i (fire_data),
    .byte_i (s_data_i),
    .last_i (s_last_i),
    .keep_i (own_q),
    .done_i (pk_done),
    .pend_o (pend),
    .word_o (pk_word),
    .be_o   (pk_be),
    .widx_o (widx)
  );

  rxwb_stats #(.LW(LW), .CW(CW)) u_stats (
    .clk_i, .rst_ni,
    .commit_i (commit),
    .add_i    (wb_len),
    .bcast_i  (is_bcast),
    .mcast_i  (is_mcast),
    .bytes_o  (cnt_bytes_o),
    .frames_o (cnt_frames_o),
    .bcast_o  (cnt_bcast_o),
    .mcast_o  (cnt_mcast_o)
  );

  // memory port mux
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_be_o    = '0;
    unique case (state_q)
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = ptr_q + AW'({fidx_q, 2'b00});
      end
      ST_DATA: if (pend) begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_q + {widx, 2'b00};
        mem_wdata_o = pk_word;
        mem_be_o    = pk_be;
      end
      ST_WB: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr_q;
        mem_wdata_o = ctl_word;
        mem_be_o    = 4'hF;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      fidx_q      <= '0;
      own_q       <= 1'b0;
      ring_q      <= 1'b0;
      buf_q       <= '0;
      last_seen_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          last_seen_q <= 1'b0;
          fidx_q      <= '0;
          if (s_valid_i) state_q <= rx_en_i ? ST_FETCH : ST_SKIP;
        end
        ST_FETCH: if (mem_ack_i) begin
          unique case (fidx_q)
            2'd0:    own_q  <= mem_rdata_i[OWN_POS];
            2'd1:    ring_q <= mem_rdata_i[RING_POS];
            default: buf_q  <= AW'(mem_rdata_i);
          endcase
          fidx_q <= fidx_q + 2'd1;
          if (fidx_q == 2'd2) state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (fire_data && s_last_i) last_seen_q <= 1'b1;
          if (last_seen_q && !pend) state_q <= ST_END;
        end
        ST_END:  state_q <= (short_ev || !own_q) ? ST_IDLE : ST_WB;
        ST_WB:   if (mem_ack_i) state_q <= ST_IDLE;
        ST_SKIP: if (s_valid_i && s_last_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      base_q <= '0;
    end else if (base_we_i) begin
      ptr_q  <= base_i;
      base_q <= base_i;
    end else if (commit) begin
      ptr_q <= ring_q ? base_q : ptr_q + AW'(DESC_BYTES);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_rx_o    <= 1'b0;
      irq_norm_o  <= 1'b0;
      irq_nobuf_o <= 1'b0;
      irq_abn_o   <= 1'b0;
    end else begin
      irq_rx_o    <= commit | short_ev;
      irq_norm_o  <= commit | short_ev;
      irq_nobuf_o <= nobuf_ev;
      irq_abn_o   <= nobuf_ev;
    end
  end

  assign cur_desc_o = ptr_q;

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r7_pulse_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_rx_o && irq_nobuf_o));

  a_r9_count_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_frames_o != $past(cnt_frames_o)) |-> (irq_rx_o && irq_norm_o));

  a_r5_ptr_change_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_desc_o != $past(cur_desc_o)) |-> ($past(base_we_i) || irq_rx_o));
endmodule

// File: tb/rxwb_engine_test.sv
module rxwb_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        rx_en, base_we, s_valid, s_last, s_ready;
  logic [31:0] base, mem_addr, mem_wdata, mem_rdata, cur_desc;
  logic [7:0]  s_data;
  logic        mem_req, mem_we, mem_ack;
  logic [3:0]  mem_be;
  logic        irq_rx, irq_norm, irq_nobuf, irq_abn;
  logic [31:0] c_bytes, c_frames, c_bcast, c_mcast;

  rxwb_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .base_we_i(base_we), .base_i(base),
    .s_data_i(s_data), .s_valid_i(s_valid), .s_last_i(s_last), .s_ready_o(s_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_be_o(mem_be), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .cur_desc_o(cur_desc),
    .irq_rx_o(irq_rx), .irq_norm_o(irq_norm), .irq_nobuf_o(irq_nobuf), .irq_abn_o(irq_abn),
    .cnt_bytes_o(c_bytes), .cnt_frames_o(c_frames), .cnt_bcast_o(c_bcast), .cnt_mcast_o(c_mcast)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // memory model: ack one cycle after request is seen
  logic [31:0] mem [0:1023];
  int rd_cnt = 0, wr_cnt = 0;
  assign mem_rdata = mem[mem_addr[11:2]];
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          for (int k = 0; k < 4; k++)
            if (mem_be[k]) mem[mem_addr[11:2]][8*k +: 8] <= mem_wdata[8*k +: 8];
          wr_cnt <= wr_cnt + 1;
        end else rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle monitor: pulse counting and counter-movement rule (R9)
  int n_rx, n_norm, n_nobuf, n_abn;
  logic [31:0] prev_frames = 0, prev_bytes = 0;
  always @(negedge clk) if (rst_n) begin
    n_rx += int'(irq_rx); n_norm += int'(irq_norm);
    n_nobuf += int'(irq_nobuf); n_abn += int'(irq_abn);
    if ((c_frames != prev_frames || c_bytes != prev_bytes) && !irq_rx)
      chk(0, "R9 counter moved without pulse", c_frames, prev_frames);
    prev_frames = c_frames; prev_bytes = c_bytes;
  end

  // reference state
  logic [31:0] m_ptr = 0, m_base = 0, m_bytes = 0, m_frames = 0, m_bc = 0, m_mc = 0;
  byte unsigned frm[$];
  int rd_at_first;

  task automatic build(input int kind, input int len);
    frm.delete();
    for (int i = 0; i < len; i++) begin
      byte unsigned b;
      b = 8'(i * 7 + 3);
      if (i < 6) begin
        if (kind == 1) b = 8'hFF;
        else if (i == 0) b = (kind == 2) ? 8'h01 : 8'h02;
      end
      frm.push_back(b);
    end
  endtask

  task automatic set_desc(input int a, input bit own, input bit ring, input int bufa);
    mem[a >> 2]       = own ? 32'h8000_0000 : 32'h0;
    mem[(a >> 2) + 1] = ring ? 32'h0000_8000 | 32'd1536 : 32'd1536;
    mem[(a >> 2) + 2] = bufa;
  endtask

  task automatic send;
    rd_at_first = -1;
    for (int i = 0; i < frm.size(); i++) begin
      s_valid = 1'b1; s_data = frm[i]; s_last = (i == frm.size() - 1);
      forever begin
        #1;
        if (s_ready) begin
          if (i == 0) rd_at_first = rd_cnt;
          @(negedge clk); break;
        end
        @(negedge clk);
      end
    end
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic run(input bit en, input string tag);
    logic [31:0] d0, d1, bufa, snap [0:31];
    int len, rd0, wr0;
    bit own, ring, shrt, bc, mc;
    len = frm.size();
    d0 = mem[m_ptr[11:2]]; d1 = mem[m_ptr[11:2] + 1]; bufa = mem[m_ptr[11:2] + 2];
    for (int k = 0; k < 32; k++) snap[k] = mem[bufa[11:2] + k];
    own = d0[31]; ring = d1[15]; shrt = len < 12;
    bc = (len >= 6) && frm[0] == 8'hFF && frm[1] == 8'hFF && frm[2] == 8'hFF &&
         frm[3] == 8'hFF && frm[4] == 8'hFF && frm[5] == 8'hFF;
    mc = frm[0][0] && !bc;
    rd0 = rd_cnt; wr0 = wr_cnt;
    rx_en = en;
    n_rx = 0; n_norm = 0; n_nobuf = 0; n_abn = 0;
    send();
    repeat (20) @(negedge clk);
    rx_en = 1'b1;
    if (!en) begin
      chk(n_rx + n_norm + n_nobuf + n_abn == 0, {"R1 pulses ", tag}, n_rx + n_nobuf, 0);
      chk(rd_cnt == rd0 && wr_cnt == wr0, {"R1 mem access ", tag}, wr_cnt - wr0, 0);
      chk(c_frames == m_frames && c_bytes == m_bytes, {"R1 counters ", tag}, c_frames, m_frames);
    end else begin
      chk(rd_at_first == rd0 + 3, {"R2 fetch before accept ", tag}, rd_at_first - rd0, 3);
      if (shrt) begin
        chk(n_rx == 1 && n_norm == 1 && n_nobuf == 0 && n_abn == 0, {"R6 pulses ", tag},
            {n_rx[7:0], n_norm[7:0], n_nobuf[7:0], n_abn[7:0]}, 32'h01010000);
        chk(mem[m_ptr[11:2]] == d0, {"R6 no writeback ", tag}, mem[m_ptr[11:2]], d0);
        chk(c_frames == m_frames && c_bytes == m_bytes, {"R6 counters ", tag}, c_frames, m_frames);
      end else if (!own) begin
        chk(n_nobuf == 1 && n_abn == 1 && n_rx == 0 && n_norm == 0, {"R7 pulses ", tag},
            {n_rx[7:0], n_norm[7:0], n_nobuf[7:0], n_abn[7:0]}, 32'h00000101);
        for (int k = 0; k < 32; k++)
          if (mem[bufa[11:2] + k] != snap[k]) chk(0, {"R7 buffer touched ", tag}, mem[bufa[11:2] + k], snap[k]);
        checks++;
        chk(c_frames == m_frames, {"R7 counters ", tag}, c_frames, m_frames);
      end else begin
        int bad = 0;
        for (int n = 0; n < len + 4; n++) begin
          logic [31:0] a; logic [7:0] got, exp;
          a = bufa + n; got = mem[a[11:2]][8*a[1:0] +: 8];
          exp = (n < len) ? frm[n] : snap[(n >> 2)][8*a[1:0] +: 8];
          if (n >= len && ((n >> 2) != ((len - 1) >> 2))) exp = got;
          if (got != exp) begin bad++; chk(0, {"R3 buffer byte ", tag}, got, exp); end
        end
        checks++;
        chk(mem[m_ptr[11:2]] == (((len + 4) << 16) | 32'h300), {"R4 ctl word ", tag},
            mem[m_ptr[11:2]], ((len + 4) << 16) | 32'h300);
        chk(n_rx == 1 && n_norm == 1 && n_nobuf == 0, {"R9 pulses ", tag}, n_rx, 1);
        m_frames += 1; m_bytes += len + 4; m_bc += bc; m_mc += mc;
        m_ptr = ring ? m_base : m_ptr + 32;
        chk(c_bytes == m_bytes && c_frames == m_frames, {"R9 counters ", tag}, c_bytes, m_bytes);
        chk(c_bcast == m_bc && c_mcast == m_mc, {"R8 class ", tag}, {c_bcast[15:0], c_mcast[15:0]},
            {m_bc[15:0], m_mc[15:0]});
      end
    end
    chk(cur_desc == m_ptr, {"R5 pointer ", tag}, cur_desc, m_ptr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rx_en = 1'b1; base_we = 1'b0; base = '0; s_valid = 1'b0; s_last = 1'b0; s_data = '0;
    for (int k = 0; k < 1024; k++) mem[k] = 32'hA5A5_A5A5;
    repeat (3) @(negedge clk);
    chk(!irq_rx && !irq_nobuf && !mem_req && !s_ready, "R9 reset outputs", {irq_rx, irq_nobuf, mem_req, s_ready}, 0);
    chk(c_bytes == 0 && c_frames == 0 && cur_desc == 0, "R9 reset counters", c_frames, 0);
    rst_n = 1'b1;
    @(negedge clk);
    base = 32'h100; base_we = 1'b1;
    @(negedge clk);
    base_we = 1'b0; m_base = 32'h100; m_ptr = 32'h100;
    @(negedge clk);
    chk(cur_desc == 32'h100, "R5 base load", cur_desc, 32'h100);

    set_desc(32'h100, 1, 0, 32'h200); build(0, 14); run(1, "unicast");
    set_desc(32'h120, 1, 1, 32'h280); build(1, 17); run(1, "bcast wrap");
    set_desc(32'h100, 1, 0, 32'h300); build(2, 12); run(1, "mcast min");
    set_desc(32'h120, 1, 0, 32'h380); build(0, 11); run(1, "short");
    set_desc(32'h120, 0, 0, 32'h380); build(0, 20); run(1, "unowned");
    set_desc(32'h120, 0, 0, 32'h380); build(2, 8);  run(1, "short unowned R6");
    set_desc(32'h120, 1, 1, 32'h400); build(1, 16); run(0, "disabled");
    build(0, 40); run(1, "long wrap");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule